// File: doc/BRIEF.md
# Ring Line State Detector with Sticky Condition Register

This block sits behind an aligned receiver that hands it one pair of 5-bit code symbols per valid strobe. It classifies the stream of pairs into ring line states: idle, super idle, active, and unknown after a known state. Each time one of these states is entered, a matching bit in a history register is set. The bit stays set until the host clears it, so the register builds up a record of every state seen since the last clear.

The same register also holds sticky bits for two error events that arrive from outside as single-cycle pulses (a connection or cascade-sync event, and an elastic buffer fault). It also holds a bit that reports when an internal pair-driven down-counter has reached zero. A mask register selects which history bits drive the single registered interrupt-condition output.

A small host port reads the history, the mask and the counter. A write to the history clears bits where the write data is 1. A write to the mask replaces it, and a write to the counter loads it.

Top module: `linestate_monitor`

## Requirements
- R1: Idle line state is entered on the second consecutive idle pair (both symbols 11111); entering it sets history bit 0. A single idle pair sets nothing.
- R2: History bit 6 (super idle) sets when the eighth consecutive idle pair arrives. Seven consecutive idle pairs do not set it.
- R3: A pair whose first symbol (bits 9:5) is 11000 and whose second (bits 4:0) is 10001 enters the active state and sets bit 2. Non-idle pairs that follow keep the active state and set no other bit.
- R4: A pair that is neither idle nor J-K, received while in the idle state, enters the unknown-valid state and sets bit 3. The same pair received before any known state was entered sets nothing.
- R5: History bits are cumulative. Writing address 0 clears exactly the bits written as 1.
- R6: If an event and a clear of the same bit occur in the same cycle, the bit ends up set.
- R7: A one-cycle pulse on `conn_evt` sets bit 4, and a pulse on `eb_err` sets bit 5. Both stay set after the pulse ends.
- R8: Writing address 2 loads the threshold counter, which decreases by one per valid pair while nonzero. Bit 1 sets once the counter is zero, and a clear cannot remove it while the counter stays zero.
- R9: `cond_irq` is 1 exactly when some history bit and the matching mask bit (address 1) are both 1. It changes in the same cycle as the register it depends on.
- R10: Bit 7 of the history and of the mask always reads 0, and writes to it are ignored.
- R11: A synchronous reset leaves history 0x02, mask 0x00, counter 0 and `cond_irq` 0.
- R12: `host_rdata` is registered. It shows the location selected by `host_addr` one clock after the address is presented. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pair_vld | input | 1 | Symbol pair strobe |
| pair_sym | input | 10 | Symbol pair, first symbol in bits 9:5 |
| conn_evt | input | 1 | Connection / sync error event pulse |
| eb_err | input | 1 | Elastic buffer fault pulse |
| host_addr | input | 2 | Register select: 0 history, 1 mask, 2 counter |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| cond_irq | output | 1 | Masked condition output |

## Verification
A wrong line-state register or a wrong idle run count is not visible at the ports until it changes which history bit a later pair sets. The clearest case is a missing or extra unknown-valid bit after a data pair, or a super idle bit that appears after seven idle pairs instead of eight. The bench therefore reads the history three cycles after each short pair sequence. A fault in the clear, set-priority or mask path shows within two cycles in `host_rdata` and `cond_irq`. A counter off by one moves the cycle in which bit 1 rises by one pair.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int HIST_W = 7;
  localparam int B_ILS  = 0;
  localparam int B_THR  = 1;
  localparam int B_ALS  = 2;
  localparam int B_UPV  = 3;
  localparam int B_CONN = 4;
  localparam int B_EB   = 5;
  localparam int B_SILS = 6;

  typedef enum logic [1:0] {
    LS_NONE   = 2'd0,
    LS_IDLE   = 2'd1,
    LS_ACTIVE = 2'd2,
    LS_UNKV   = 2'd3
  } ls_e;

  typedef enum logic [1:0] {
    A_HIST = 2'd0,
    A_MASK = 2'd1,
    A_THR  = 2'd2,
    A_NONE = 2'd3
  } haddr_e;
endpackage

// File: rtl/lsm_classifier.sv
module lsm_classifier
  import lsm_pkg::*;
#(
  parameter int SYM_W = 5,
  parameter int ILS_PAIRS = 2,
  parameter int SILS_PAIRS = 8,
  parameter logic [SYM_W-1:0] J_CODE = 5'b11000,
  parameter logic [SYM_W-1:0] K_CODE = 5'b10001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pair_vld,
  input  logic [2*SYM_W-1:0] pair_sym,
  output logic             ev_ils,
  output logic             ev_sils,
  output logic             ev_als,
  output logic             ev_upv
);
  localparam int PAIR_W = 2 * SYM_W;
  localparam int RUN_W = $clog2(SILS_PAIRS + 1);
  localparam logic [PAIR_W-1:0] IDLE_PAIR = {PAIR_W{1'b1}};
  localparam logic [PAIR_W-1:0] JK_PAIR = {J_CODE, K_CODE};

  ls_e              state_q;
  logic [RUN_W-1:0] run_q, run_inc;
  logic             is_idle, is_jk;

  always_comb begin
    is_idle = (pair_sym == IDLE_PAIR);
    is_jk   = (pair_sym == JK_PAIR);
    run_inc = (run_q == RUN_W'(SILS_PAIRS)) ? run_q : run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LS_NONE;
      run_q   <= '0;
      ev_ils  <= 1'b0;
      ev_sils <= 1'b0;
      ev_als  <= 1'b0;
      ev_upv  <= 1'b0;
    end else begin
      ev_ils  <= 1'b0;
      ev_sils <= 1'b0;
      ev_als  <= 1'b0;
      ev_upv  <= 1'b0;
      if (pair_vld) begin
        if (is_idle) begin
          run_q <= run_inc;
          if (run_inc >= RUN_W'(ILS_PAIRS) && state_q != LS_IDLE) begin
            state_q <= LS_IDLE;
            ev_ils  <= 1'b1;
          end
          if (run_inc == RUN_W'(SILS_PAIRS) && run_q != RUN_W'(SILS_PAIRS))
            ev_sils <= 1'b1;
        end else if (is_jk) begin
          run_q <= '0;
          if (state_q != LS_ACTIVE) begin
            state_q <= LS_ACTIVE;
            ev_als  <= 1'b1;
          end
        end else begin
          run_q <= '0;
          if (state_q == LS_IDLE) begin
            state_q <= LS_UNKV;
            ev_upv  <= 1'b1;
          end
        end
      end
    end
  end

  // R3
  als_src_chk: assert property (@(posedge clk) disable iff (rst)
    ev_als |-> $past(pair_vld && pair_sym == JK_PAIR));

  // R4
  upv_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ev_upv |-> $past(state_q == LS_IDLE));

  // R2
  sils_run_chk: assert property (@(posedge clk) disable iff (rst)
    ev_sils |-> $past(run_q) == RUN_W'(SILS_PAIRS - 1));
endmodule

// File: rtl/lsm_thr_cnt.sv
module lsm_thr_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             at_zero
);
  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (dec && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign at_zero = (cnt == '0);

  // R8
  thr_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  // R8
  thr_hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == '0) |=> cnt == '0);
endmodule

// File: rtl/lsm_cond_reg.sv
module lsm_cond_reg #(
  parameter int HIST_W = 7,
  parameter logic [HIST_W-1:0] HIST_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HIST_W-1:0] ev,
  input  logic              clr_we,
  input  logic [HIST_W-1:0] clr_bits,
  input  logic              mask_we,
  input  logic [HIST_W-1:0] mask_val,
  output logic [HIST_W-1:0] hist_q,
  output logic [HIST_W-1:0] mask_q,
  output logic              irq_q
);
  logic [HIST_W-1:0] clr_vec, hist_d, mask_d;

  always_comb begin
    clr_vec = clr_we ? clr_bits : '0;
    hist_d  = (hist_q & ~clr_vec) | ev;
    mask_d  = mask_we ? mask_val : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= HIST_RST;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      mask_q <= mask_d;
      irq_q  <= |(hist_d & mask_d);
    end
  end

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(hist_q) & ~$past(clr_vec)) & ~hist_q) == '0));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (ev != '0) |=> ((hist_q & $past(ev)) == $past(ev)));

  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(hist_q & mask_q));
endmodule

// File: rtl/linestate_monitor.sv
module linestate_monitor
  import lsm_pkg::*;
#(
  parameter int SYM_W = 5,
  parameter int CNT_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pair_vld,
  input  logic [2*SYM_W-1:0]  pair_sym,
  input  logic                conn_evt,
  input  logic                eb_err,
  input  logic [1:0]          host_addr,
  input  logic                host_wr,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic [DATA_W-1:0]   host_rdata,
  output logic                cond_irq
);
  localparam logic [HIST_W-1:0] HIST_RST = HIST_W'(1) << B_THR;

  logic              ev_ils, ev_sils, ev_als, ev_upv;
  logic [CNT_W-1:0]  cnt;
  logic              at_zero;
  logic [HIST_W-1:0] ev_vec, hist, mask;
  logic              wr_hist, wr_mask, wr_thr;

  always_comb begin
    wr_hist = host_wr && host_addr == A_HIST;
    wr_mask = host_wr && host_addr == A_MASK;
    wr_thr  = host_wr && host_addr == A_THR;
    ev_vec  = '0;
    ev_vec[B_ILS]  = ev_ils;
    ev_vec[B_THR]  = at_zero;
    ev_vec[B_ALS]  = ev_als;
    ev_vec[B_UPV]  = ev_upv;
    ev_vec[B_CONN] = conn_evt;
    ev_vec[B_EB]   = eb_err;
    ev_vec[B_SILS] = ev_sils;
  end

  lsm_classifier #(.SYM_W(SYM_W)) u_cls (
    .clk(clk), .rst(rst), .pair_vld(pair_vld), .pair_sym(pair_sym),
    .ev_ils(ev_ils), .ev_sils(ev_sils), .ev_als(ev_als), .ev_upv(ev_upv)
  );

  lsm_thr_cnt #(.CNT_W(CNT_W)) u_thr (
    .clk(clk), .rst(rst), .load(wr_thr), .load_val(host_wdata[CNT_W-1:0]),
    .dec(pair_vld), .cnt(cnt), .at_zero(at_zero)
  );

  lsm_cond_reg #(.HIST_W(HIST_W), .HIST_RST(HIST_RST)) u_cond (
    .clk(clk), .rst(rst), .ev(ev_vec),
    .clr_we(wr_hist), .clr_bits(host_wdata[HIST_W-1:0]),
    .mask_we(wr_mask), .mask_val(host_wdata[HIST_W-1:0]),
    .hist_q(hist), .mask_q(mask), .irq_q(cond_irq)
  );

  always_ff @(posedge clk) begin
    if (rst)
      host_rdata <= '0;
    else begin
      unique case (host_addr)
        A_HIST:  host_rdata <= DATA_W'(hist);
        A_MASK:  host_rdata <= DATA_W'(mask);
        A_THR:   host_rdata <= DATA_W'(cnt);
        default: host_rdata <= '0;
      endcase
    end
  end

  // R10
  rsv_bit_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(host_addr) != A_THR) |-> !host_rdata[HIST_W]);
endmodule

// File: tb/sim_linestate_monitor.sv
module sim_linestate_monitor;
  logic       clk = 0;
  logic       rst = 1;
  logic       pair_vld = 0;
  logic [9:0] pair_sym = '0;
  logic       conn_evt = 0, eb_err = 0;
  logic [1:0] host_addr = 0;
  logic       host_wr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic       cond_irq;

  localparam logic [9:0] IDLE = 10'h3FF;
  localparam logic [9:0] JK   = {5'b11000, 5'b10001};
  localparam logic [9:0] DATA = 10'h2AA;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] q_exp[$];
  string      q_tag[$];
  logic       req = 0, req_q = 0;

  always #10 clk = ~clk;

  linestate_monitor u0 (
    .clk(clk), .rst(rst), .pair_vld(pair_vld), .pair_sym(pair_sym),
    .conn_evt(conn_evt), .eb_err(eb_err), .host_addr(host_addr),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cond_irq(cond_irq)
  );

  // monitor: R12 read data appears one clock after the address
  always @(posedge clk) req_q <= req;
  always @(negedge clk) begin
    if (req_q && q_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (host_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual %02h expected %02h", t, host_rdata, e);
      end
    end
  end

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    host_addr = a;
    q_exp.push_back(e);
    q_tag.push_back(t);
    req = 1;
    @(negedge clk);
    req = 0;
  endtask

  task automatic irq_chk(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (cond_irq !== e) begin
      errors++;
      $display("FAIL %s: cond_irq actual %0b expected %0b", t, cond_irq, e);
    end
  endtask

  task automatic send(input logic [9:0] p, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pair_sym = p;
      pair_vld = 1;
    end
    @(negedge clk);
    pair_vld = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    host_wdata = d;
    host_wr = 1;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    rd_chk(0, 8'h02, "R11 hist");
    rd_chk(1, 8'h00, "R11 mask");
    rd_chk(2, 8'h00, "R11 cnt");
    irq_chk(0, "R11 irq");
    // R4 no known state yet
    send(DATA, 1);
    rd_chk(0, 8'h02, "R4 from reset");
    wr(2, 8'd200);
    wr(0, 8'hFF);
    rd_chk(0, 8'h00, "R5 clear all");
    // R1 idle
    send(IDLE, 1);
    rd_chk(0, 8'h00, "R1 one pair");
    send(IDLE, 1);
    rd_chk(0, 8'h01, "R1 two pairs");
    // R2 super idle
    send(IDLE, 5);
    rd_chk(0, 8'h01, "R2 seven pairs");
    send(IDLE, 1);
    rd_chk(0, 8'h41, "R2 eight pairs");
    wr(0, 8'hFF);
    // R4 drop from idle
    send(DATA, 1);
    rd_chk(0, 8'h08, "R4 idle to unknown");
    wr(0, 8'hFF);
    // R3 active
    send(JK, 1);
    rd_chk(0, 8'h04, "R3 jk");
    send(DATA, 3);
    send(IDLE, 1);
    send(DATA, 1);
    rd_chk(0, 8'h04, "R3 data keeps active");
    wr(0, 8'h04);
    // R7 external events
    @(negedge clk); eb_err = 1;
    @(negedge clk); eb_err = 0;
    repeat (3) @(negedge clk);
    rd_chk(0, 8'h20, "R7 eb sticky");
    // R9 mask
    wr(1, 8'h04);
    irq_chk(0, "R9 unmatched mask");
    wr(1, 8'h20);
    irq_chk(1, "R9 matched mask");
    wr(0, 8'h20);
    irq_chk(0, "R9 after clear");
    rd_chk(0, 8'h00, "R5 write-1 clear");
    // R10 reserved
    wr(1, 8'hFF);
    rd_chk(1, 8'h7F, "R10 mask bit7");
    wr(0, 8'h80);
    rd_chk(0, 8'h00, "R10 hist bit7");
    // R6 set wins, R7 conn
    @(negedge clk);
    conn_evt = 1; host_addr = 0; host_wdata = 8'h10; host_wr = 1;
    @(negedge clk);
    conn_evt = 0; host_wr = 0;
    rd_chk(0, 8'h10, "R6 set over clear");
    irq_chk(1, "R9 conn masked");
    wr(0, 8'hFF);
    // R8 counter: 15 pairs since load of 200
    rd_chk(2, 8'd185, "R8 decrement");
    wr(2, 8'd3);
    wr(0, 8'hFF);
    send(DATA, 2);
    rd_chk(0, 8'h00, "R8 not yet zero");
    send(DATA, 1);
    rd_chk(0, 8'h02, "R8 zero sets");
    wr(0, 8'h02);
    rd_chk(0, 8'h02, "R8 clear while zero");
    rd_chk(3, 8'h00, "R12 addr3");
    // R11 mid-run reset
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd_chk(0, 8'h02, "R11 hist again");
    rd_chk(1, 8'h00, "R11 mask again");
    irq_chk(0, "R11 irq again");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule